// File: doc/BRIEF.md
# Clocked Serial Transmitter with Single Transmit Buffer

This block sends 8-bit frames over a synchronous serial link. It is the clock master: it makes its own shift clock from the system clock through a programmable divider and drives that clock out next to the data line. The peer device samples the data on the rising edges of that clock. A single holding buffer sits in front of the shift register, so software or a DMA engine can write the next byte while the current one is still going out.

Each byte written to the empty buffer moves into the shift register as soon as the shifter is free and transmission is enabled. That move empties the buffer again and raises a buffer-empty request. The same request is raised when transmission is switched on while the buffer is empty. The request sets a pending interrupt flag and pulses a DMA request in the same cycle. The flag stays set until it is acknowledged or cleared. A busy status covers the whole span from the buffer write to the last shifted bit.

The shifter is a three-state machine. IDLE holds the clock and data lines high. LOW is the low half of a bit cell; the data bit is presented at its start. HIGH is the high half, and the peer samples at its start. Its transitions are named as follows. START goes from IDLE to LOW when the buffer is full and transmission is enabled. RISE goes from LOW to HIGH when a half period has elapsed. NEXT_BIT goes from HIGH to LOW when a half period has elapsed and bits remain. RELOAD goes from HIGH to LOW after the last bit when the buffer is full and transmission is enabled. FINISH goes from HIGH to IDLE after the last bit otherwise.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset: sclk_o=1, txd_o=1, buf_empty=1, tx_busy=0, overrun=0, irq_pend=0, dma_req=0.
- R2: A frame is 8 bits sent least significant bit first. txd_o takes each bit when sclk_o falls and holds it through the whole low half. Between frames sclk_o and txd_o are both 1. Each half period of sclk_o lasts div_val+1 system clocks, so a lone frame keeps tx_busy high for 16*(div_val+1)+1 sampled cycles from the write.
- R3: A write (wr_en=1) with the buffer empty is accepted. After that edge buf_empty=0 and tx_busy=1. If the shifter is idle and tx_enable=1, the byte moves to the shifter at the next edge and buf_empty returns to 1.
- R4: With irq_en=1, the edge that moves a byte from the buffer to the shifter sets irq_pend and drives dma_req high for exactly one cycle.
- R5: With irq_en=1, a rise of tx_enable while the buffer is empty sets irq_pend and pulses dma_req at the next edge.
- R6: irq_pend stays set until an irq_ack or irq_clr pulse. A new request in the same cycle as the acknowledge or clear leaves it set.
- R7: With irq_en=0, a transfer neither sets irq_pend nor pulses dma_req.
- R8: A write while the buffer is full is ignored: the buffered byte is kept and sent, and overrun becomes 1. The next accepted write clears overrun.
- R9: A byte written during a frame is sent straight after it, with no idle gap. tx_busy stays 1 until the last bit of the last frame has finished, then falls.
- R10: When tx_enable goes low, the frame in progress completes. No new frame starts: sclk_o stays high and a buffered byte waits with tx_busy=1. No dma_req is issued until tx_enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmit enable control bit |
| div_val | input | 8 | Half-period divider; half period = div_val+1 clocks |
| irq_en | input | 1 | Enables interrupt and DMA requests |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to write into the transmit buffer |
| irq_ack | input | 1 | Acknowledge strobe (vector read) clearing irq_pend |
| irq_clr | input | 1 | Software clear of irq_pend |
| sclk_o | output | 1 | Generated shift clock, idles high |
| txd_o | output | 1 | Serial data out, idles high |
| buf_empty | output | 1 | Transmit buffer empty status |
| tx_busy | output | 1 | Transmission in progress status |
| overrun | output | 1 | A write was dropped because the buffer was full |
| irq_pend | output | 1 | Pending transmit interrupt request |
| dma_req | output | 1 | One-cycle DMA request, same timing as the interrupt request |

## Verification
Two pairs of functions can meet in one cycle. In the first pair, an acknowledge or clear of the pending flag can arrive in the very cycle a buffer-to-shifter transfer raises a new request. The bench pulses irq_ack in the cycle after a write, which is the cycle of the transfer, and requires irq_pend to still be set afterwards. In the second pair, a second write can arrive in the same cycle the buffer empties into the shifter. The bench issues the two writes on consecutive cycles. It expects the second write to be rejected with overrun set, and expects only the first byte on the line.

// File: rtl/sst_pkg.sv
package sst_pkg;
    // Bit 0 set only in the low half, so the clock output is a flop bit.
    typedef enum logic [1:0] {
        SH_IDLE = 2'b00,
        SH_LOW  = 2'b01,
        SH_HIGH = 2'b10
    } sh_state_e;
endpackage

// File: rtl/sst_halfcnt.sv
module sst_halfcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] div,
    output logic          half_done
);
    logic [CW-1:0] cnt;

    assign half_done = (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || half_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sst_buffer.sv
module sst_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    input  logic          frame_end,
    output logic          buf_full,
    output logic [DW-1:0] buf_data,
    output logic          overrun,
    output logic          busy
);
    logic accept;
    logic reject;

    assign accept = wr_en && !buf_full;
    assign reject = wr_en && buf_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (take) begin
            buf_full <= 1'b0;
        end else if (accept) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (reject) begin
            overrun <= 1'b1;
        end else if (accept) begin
            overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (frame_end && !buf_full) begin
            busy <= 1'b0;
        end
    end

    AST_BUSY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> busy); // R3
    AST_OVR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> overrun); // R8
    AST_REJECT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !take) |=> $stable(buf_data)); // R8
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    input  logic [CW-1:0] div,
    output logic          take,
    output logic          frame_end,
    output logic          sclk_o,
    output logic          txd_o
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    sh_state_e      state, nxt;
    logic [DW-1:0]  shreg;
    logic [BCW-1:0] bit_cnt;
    logic           half_done;
    logic           shift;
    logic           last;

    assign last = (bit_cnt == LAST_BIT);

    sst_halfcnt #(.CW(CW)) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (state == SH_IDLE),
        .div      (div),
        .half_done(half_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and transition strobes
    always_comb begin
        nxt       = state;
        take      = 1'b0;
        frame_end = 1'b0;
        shift     = 1'b0;
        unique case (state)
            SH_IDLE: begin
                if (tx_enable && buf_full) begin      // START
                    take = 1'b1;
                    nxt  = SH_LOW;
                end
            end
            SH_LOW: begin
                if (half_done) begin                  // RISE
                    nxt = SH_HIGH;
                end
            end
            SH_HIGH: begin
                if (half_done) begin
                    if (!last) begin                  // NEXT_BIT
                        shift = 1'b1;
                        nxt   = SH_LOW;
                    end else if (tx_enable && buf_full) begin  // RELOAD
                        take = 1'b1;
                        nxt  = SH_LOW;
                    end else begin                    // FINISH
                        frame_end = 1'b1;
                        nxt       = SH_IDLE;
                    end
                end
            end
            default: nxt = SH_IDLE;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (take) begin
            shreg   <= buf_data;
            bit_cnt <= '0;
        end else if (shift) begin
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        sclk_o = !state[0];
        txd_o  = (state == SH_IDLE) ? 1'b1 : shreg[0];
    end

    AST_TXD_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_LOW && !half_done) |=> $stable(txd_o)); // R2
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE && !tx_enable) |=> (state == SH_IDLE)); // R10
endmodule

// File: rtl/sst_req.sv
module sst_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic buf_full,
    input  logic take,
    input  logic irq_en,
    input  logic irq_ack,
    input  logic irq_clr,
    output logic irq_pend,
    output logic dma_req
);
    logic en_q;
    logic en_rise;
    logic evt;

    assign en_rise = tx_enable && !en_q && !buf_full;
    assign evt     = (en_rise || take) && tx_enable && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            en_q    <= tx_enable;
            dma_req <= evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
        end else if (evt) begin
            irq_pend <= 1'b1;
        end else if (irq_ack || irq_clr) begin
            irq_pend <= 1'b0;
        end
    end

    AST_DMA_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> irq_pend); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_ack && !irq_clr) |=> irq_pend); // R6
    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !dma_req); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> !dma_req); // R10
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic [CW-1:0] div_val,
    input  logic          irq_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_ack,
    input  logic          irq_clr,
    output logic          sclk_o,
    output logic          txd_o,
    output logic          buf_empty,
    output logic          tx_busy,
    output logic          overrun,
    output logic          irq_pend,
    output logic          dma_req
);
    logic          buf_full;
    logic [DW-1:0] buf_data;
    logic          take;
    logic          frame_end;

    sst_buffer #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .frame_end(frame_end),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .overrun  (overrun),
        .busy     (tx_busy)
    );

    sst_shifter #(.DW(DW), .CW(CW)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_enable(tx_enable),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .div      (div_val),
        .take     (take),
        .frame_end(frame_end),
        .sclk_o   (sclk_o),
        .txd_o    (txd_o)
    );

    sst_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_enable(tx_enable),
        .buf_full (buf_full),
        .take     (take),
        .irq_en   (irq_en),
        .irq_ack  (irq_ack),
        .irq_clr  (irq_clr),
        .irq_pend (irq_pend),
        .dma_req  (dma_req)
    );

    assign buf_empty = !buf_full;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (sclk_o && txd_o)); // R9
    AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> buf_empty); // R3
endmodule

// File: tb/sim_sync_ser_tx.sv
module sim_sync_ser_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic [7:0] div_val = 8'd2;
    logic       irq_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_ack = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sclk, txd, buf_empty, tx_busy, overrun, irq_pend, dma_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    sync_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .div_val(div_val),
        .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
        .irq_clr(irq_clr), .sclk_o(sclk), .txd_o(txd), .buf_empty(buf_empty),
        .tx_busy(tx_busy), .overrun(overrun), .irq_pend(irq_pend), .dma_req(dma_req)
    );

    // Line monitor: receiver samples on rising shift clock
    logic       mon_on = 1'b0;
    logic [7:0] rx_sh = 8'h00;
    int         rx_bits = 0;
    int         ngot = 0;
    logic [7:0] got [0:15];

    always @(posedge sclk) begin
        if (mon_on) begin
            rx_sh = {txd, rx_sh[7:1]};
            rx_bits++;
            if (rx_bits == 8) begin
                if (ngot < 16) got[ngot] = rx_sh;
                ngot++;
                rx_bits = 0;
            end
        end
    end

    int   busy_cnt = 0;
    int   dma_cnt = 0;
    int   low_glitch = 0;
    logic sclk_p = 1'b1;
    logic txd_p = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_busy) busy_cnt++;
            if (dma_req) dma_cnt++;
            if (!sclk && !sclk_p && txd != txd_p) low_glitch++;
        end
        sclk_p = sclk;
        txd_p  = txd;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        ngot = 0;
        rx_bits = 0;
        busy_cnt = 0;
        dma_cnt = 0;
    endtask

    // Drives a one-cycle write; returns at the negedge after the accepting edge
    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 5000 && tx_busy; n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 sclk", sclk, 1);
        check("R1 txd", txd, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R1 busy", tx_busy, 0);
        check("R1 overrun", overrun, 0);
        check("R1 irq_pend", irq_pend, 0);
        check("R1 dma_req", dma_req, 0);
    endtask

    task automatic t_enable_rise();
        tx_enable = 1'b1;
        @(negedge clk);
        check("R5 irq on enable", irq_pend, 1);
        check("R5 dma on enable", dma_req, 1);
        @(negedge clk);
        check("R5 dma one cycle", dma_req, 0);
    endtask

    task automatic t_single(input logic [7:0] d, input int dv);
        div_val = 8'(dv);
        pulse_clr();
        mon_clear();
        write_byte(d);
        check("R3 buf not empty", buf_empty, 0);
        check("R3 busy set", tx_busy, 1);
        @(negedge clk);
        check("R3 moved to shifter", buf_empty, 1);
        check("R4 irq on transfer", irq_pend, 1);
        check("R4 dma on transfer", dma_req, 1);
        @(negedge clk);
        check("R4 dma one cycle", dma_req, 0);
        wait_idle();
        check("R2 one frame", ngot, 1);
        check("R2 lsb first data", got[0], d);
        check("R2 frame length", busy_cnt, 16 * (dv + 1) + 1);
        check("R2 idle lines", {sclk, txd}, 3);
        check("R2 txd held in low half", low_glitch, 0);
        check("R9 busy cleared", tx_busy, 0);
    endtask

    task automatic t_ack_collide();
        check("R6 pend before", irq_pend, 1);
        repeat (3) @(negedge clk);
        check("R6 held without ack", irq_pend, 1);
        write_byte(8'h3C);
        irq_ack = 1'b1;           // same cycle as the transfer
        @(negedge clk);
        irq_ack = 1'b0;
        check("R6 new request beats ack", irq_pend, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R6 ack clears", irq_pend, 0);
        wait_idle();
        pulse_clr();
        check("R6 clr keeps clear", irq_pend, 0);
    endtask

    task automatic t_masked();
        irq_en = 1'b0;
        mon_clear();
        write_byte(8'h81);
        @(negedge clk);
        check("R7 no irq when masked", irq_pend, 0);
        wait_idle();
        check("R7 no dma when masked", dma_cnt, 0);
        check("R7 frame still sent", got[0], 8'h81);
        irq_en = 1'b1;
    endtask

    task automatic t_overrun();
        mon_clear();
        write_byte(8'hA6);
        write_byte(8'h11);        // lands in the transfer cycle: rejected
        check("R8 overrun set", overrun, 1);
        check("R8 buffer empty after load", buf_empty, 1);
        wait_idle();
        check("R8 only first frame", ngot, 1);
        check("R8 kept byte sent", got[0], 8'hA6);
        write_byte(8'h5A);
        check("R8 overrun cleared", overrun, 0);
        wait_idle();
        check("R8 next byte", got[1], 8'h5A);
    endtask

    task automatic t_back_to_back(input int dv);
        div_val = 8'(dv);
        mon_clear();
        write_byte(8'hC3);
        @(negedge clk);
        write_byte(8'h96);
        check("R9 second byte buffered", buf_empty, 0);
        wait_idle();
        check("R9 two frames", ngot, 2);
        check("R9 first", got[0], 8'hC3);
        check("R9 second", got[1], 8'h96);
        check("R9 no gap", busy_cnt, 32 * (dv + 1) + 1);
        check("R9 busy falls", tx_busy, 0);
    endtask

    task automatic t_disable();
        div_val = 8'd1;
        pulse_clr();
        mon_clear();
        write_byte(8'hE7);
        repeat (5) @(negedge clk);
        tx_enable = 1'b0;
        write_byte(8'h42);
        for (int n = 0; n < 200 && ngot < 1; n++) @(negedge clk);
        repeat (60) @(negedge clk);
        check("R10 frame completed", got[0], 8'hE7);
        check("R10 no new frame", ngot, 1);
        check("R10 clock idle", sclk, 1);
        check("R10 byte waits busy", tx_busy, 1);
        check("R10 buffer still full", buf_empty, 0);
        check("R10 one dma only", dma_cnt, 1);
        tx_enable = 1'b1;
        wait_idle();
        check("R10 resumes", ngot, 2);
        check("R10 resumed byte", got[1], 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        t_reset();
        t_enable_rise();
        t_single(8'hB4, 2);
        t_single(8'h01, 0);
        t_ack_collide();
        t_masked();
        t_overrun();
        t_back_to_back(3);
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule